// File: doc/BRIEF.md
# Paging-Structure Translation Cache

This block is a small store of non-leaf page-table pointers that sits beside a hardware page-table walker. Each entry is keyed by the leading page-table index fields of a 48-bit virtual address, not by where the page-table entry lives in physical memory. There are three kinds of entry. The shortest kind maps the top-level index to the base of the next table down. The middle kind maps the first two indices to the base of the table after that. The longest kind maps the first three indices to the base of the last-level table. Leaf translations are never stored here.

On a lookup all three kinds are compared against the address in the same cycle. The deepest matching entry is returned, together with the level at which the walker should resume and the physical base of that table. A miss tells the walker to start from the root. The walker installs entries through a fill port. Stale pointers are removed by a flush of everything or by a flush of every entry whose prefix matches a given address.

Top module: `ps_xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a fill has been accepted.
- R2: On a miss, or whenever `lk_valid` is low, `lk_hit`, `lk_level` and `lk_base` are all 0. Level 0 means the walk starts at the root.
- R3: An entry matches only on its own prefix. The resume-3 kind compares VA bits 47:39, the resume-2 kind compares 47:30 and the resume-1 kind compares 47:21. All lower bits are ignored.
- R4: `fill_level` selects the kind. 3 stores a top-level-index entry holding the third-level table base. 2 stores a two-index entry holding the second-level table base. 1 stores a three-index entry holding the last-level table base. A fill with `fill_level` = 0 changes nothing. A hit reports the resume level of the entry that supplied the base.
- R5: When entries of several kinds match, the result comes from the longest prefix: resume level 1 before 2, and 2 before 3.
- R6: The lookup is combinational and uses the contents held before the clock edge. A fill in the same cycle becomes visible from the next cycle.
- R7: A fill whose kind and prefix match a valid entry overwrites that entry's base in place. It does not occupy a new slot and does not move the replacement pointer.
- R8: Each kind has 4 fully associative slots. New entries are placed round-robin starting at slot 0, and each kind keeps its own pointer.
- R9: `flush_all` invalidates every entry at the next edge and discards a fill presented in the same cycle.
- R10: `flush_va_valid` invalidates, in all three kinds, every entry whose prefix equals the corresponding bits of `flush_va`. A fill in the same cycle is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to look up |
| lk_hit | output | 1 | A cached pointer was found |
| lk_level | output | 2 | Resume level 3, 2 or 1; 0 on miss |
| lk_base | output | 40 | Physical base of the table to resume from |
| fill_valid | input | 1 | Install request from the walker |
| fill_level | input | 2 | Kind to install (3, 2, 1; 0 ignored) |
| fill_va | input | 48 | Address whose prefix forms the tag |
| fill_base | input | 40 | Table base to store |
| flush_all | input | 1 | Invalidate everything |
| flush_va_valid | input | 1 | Invalidate entries matching `flush_va` |
| flush_va | input | 48 | Address for the selective flush |

## Verification
The assertions check on every cycle that a miss drives zero level and base, and that no hit appears without a lookup request. They also check that a lookup in the cycle after a full flush misses, and that an address flushed selectively misses on the next cycle. Finally, they check that a fill is found on the next cycle at its own depth or deeper. Round-robin eviction order, in-place overwrite of a duplicate prefix and the choice of the longest prefix among coexisting entries depend on the history of fills. Only the bench's scenarios, compared against its reference model, can show these behaviours.

// File: rtl/ps_xlat_cache.sv
module ps_xlat_cache #(
  parameter int VA_W    = 48,
  parameter int BASE_W  = 40,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [1:0]        lk_level,
  output logic [BASE_W-1:0] lk_base,
  input  logic              fill_valid,
  input  logic [1:0]        fill_level,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [BASE_W-1:0] fill_base,
  input  logic              flush_all,
  input  logic              flush_va_valid,
  input  logic [VA_W-1:0]   flush_va
);
  localparam int TAG_W = VA_W - 21;
  localparam int IDX_W = 9;
  localparam int KINDS = 3;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [KINDS-1:0] kind_hit;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    localparam logic [TAG_W-1:0] MSK = {TAG_W{1'b1}} << (TAG_W - IDX_W * (k + 1));

    logic [ENTRIES-1:0] vld_q, lk_m, fl_m, fu_m;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [BASE_W-1:0]  base_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q, fidx;
    logic [BASE_W-1:0]  base_sel;
    logic               fdup;
    wire                fill_here = fill_valid && (fill_level == 2'(3 - k));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign lk_m[e] = vld_q[e] && (((tag_q[e] ^ lk_va[VA_W-1:21]) & MSK) == '0);
      assign fl_m[e] = vld_q[e] && (((tag_q[e] ^ flush_va[VA_W-1:21]) & MSK) == '0);
      assign fu_m[e] = vld_q[e] && (((tag_q[e] ^ fill_va[VA_W-1:21]) & MSK) == '0);
    end

    assign kind_hit[k] = |lk_m;
    assign fdup        = |fu_m;

    always_comb begin
      base_sel = '0;
      fidx     = ptr_q;
      for (int e = 0; e < ENTRIES; e++) begin
        if (lk_m[e]) base_sel = base_q[e];
        if (fu_m[e]) fidx = PTR_W'(e);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        ptr_q <= '0;
      end else if (flush_all) begin
        vld_q <= '0;
      end else begin
        vld_q <= flush_va_valid ? (vld_q & ~fl_m) : vld_q;
        if (fill_here) begin
          vld_q[fidx] <= 1'b1;
          if (!fdup) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst_n && !flush_all && fill_here) begin
        tag_q[fidx]  <= fill_va[VA_W-1:21] & MSK;
        base_q[fidx] <= fill_base;
      end
    end
  end

  assign lk_hit = lk_valid && (|kind_hit);

  always_comb begin
    lk_level = 2'd0;
    lk_base  = '0;
    if (lk_valid) begin
      if (kind_hit[2]) begin
        lk_level = 2'd1;
        lk_base  = g_kind[2].base_sel;
      end else if (kind_hit[1]) begin
        lk_level = 2'd2;
        lk_base  = g_kind[1].base_sel;
      end else if (kind_hit[0]) begin
        lk_level = 2'd3;
        lk_base  = g_kind[0].base_sel;
      end
    end
  end
endmodule

// File: rtl/ps_xlat_cache_chk.sv
module ps_xlat_cache_chk #(
  parameter int VA_W   = 48,
  parameter int BASE_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_va,
  input logic              lk_hit,
  input logic [1:0]        lk_level,
  input logic [BASE_W-1:0] lk_base,
  input logic              fill_valid,
  input logic [1:0]        fill_level,
  input logic [VA_W-1:0]   fill_va,
  input logic              flush_all,
  input logic              flush_va_valid,
  input logic [VA_W-1:0]   flush_va
);
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_level == 2'd0 && lk_base == '0));

  assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  assert_flush_all_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit);

  assert_flush_addr_misses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_va_valid && !fill_valid) |=> !(lk_valid && lk_va == $past(flush_va)) || !lk_hit);

  assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_level != 2'd0 && !flush_all && !flush_va_valid)
    |=> !(lk_valid && lk_va == $past(fill_va))
        || (lk_hit && lk_level != 2'd0 && lk_level <= $past(fill_level)));
endmodule

bind ps_xlat_cache ps_xlat_cache_chk #(.VA_W(VA_W), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_hit(lk_hit),
  .lk_level(lk_level), .lk_base(lk_base), .fill_valid(fill_valid),
  .fill_level(fill_level), .fill_va(fill_va), .flush_all(flush_all),
  .flush_va_valid(flush_va_valid), .flush_va(flush_va)
);

// File: tb/tb_ps_xlat_cache.sv
module tb_ps_xlat_cache;
  localparam int VA_W = 48, BASE_W = 40, N = 4, TW = 27;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_valid = 0, flush_all = 0, flush_va_valid = 0;
  logic [VA_W-1:0] lk_va = '0, fill_va = '0, flush_va = '0;
  logic [1:0] fill_level = '0, lk_level;
  logic [BASE_W-1:0] fill_base = '0, lk_base;
  logic lk_hit;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ps_xlat_cache dut (.*);

  logic          m_val  [3][N];
  logic [TW-1:0] m_tag  [3][N];
  logic [BASE_W-1:0] m_base [3][N];
  int            m_ptr  [3];

  function automatic logic [TW-1:0] kmask(int k);
    return {TW{1'b1}} << (TW - 9 * (k + 1));
  endfunction

  function automatic logic [VA_W-1:0] mkva(int a, int b, int c, logic [20:0] lo);
    return {9'(a), 9'(b), 9'(c), lo};
  endfunction

  function automatic int mfind(int k, logic [VA_W-1:0] va);
    for (int e = 0; e < N; e++)
      if (m_val[k][e] && (((m_tag[k][e] ^ va[VA_W-1:21]) & kmask(k)) == '0)) return e;
    return -1;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_ptr[k] = 0;
      for (int e = 0; e < N; e++) m_val[k][e] = 0;
    end
  endtask

  task automatic cyc(input logic lv, input logic [VA_W-1:0] lva,
                     input logic fv, input logic [1:0] fl, input logic [VA_W-1:0] fva,
                     input logic [BASE_W-1:0] fb, input logic fa, input logic fvv,
                     input logic [VA_W-1:0] fla, input string req);
    logic e_hit; logic [1:0] e_lvl; logic [BASE_W-1:0] e_base;
    int dup, k;
    @(negedge clk);
    lk_valid = lv; lk_va = lva; fill_valid = fv; fill_level = fl; fill_va = fva;
    fill_base = fb; flush_all = fa; flush_va_valid = fvv; flush_va = fla;
    e_hit = 0; e_lvl = 0; e_base = '0;
    if (lv) begin
      for (int kk = 0; kk < 3; kk++) begin
        int i;
        i = mfind(kk, lva);
        if (i >= 0) begin e_hit = 1; e_lvl = 2'(3 - kk); e_base = m_base[kk][i]; end
      end
    end
    #2;
    checks++;
    if (lk_hit !== e_hit || lk_level !== e_lvl || lk_base !== e_base) begin
      fails++;
      $display("FAIL %s: got hit=%0b lvl=%0d base=%h, expected hit=%0b lvl=%0d base=%h",
               req, lk_hit, lk_level, lk_base, e_hit, e_lvl, e_base);
    end
    if (fa) begin
      for (int kk = 0; kk < 3; kk++) for (int e = 0; e < N; e++) m_val[kk][e] = 0;
    end else begin
      k = 3 - int'(fl);
      dup = (fv && fl != 0) ? mfind(k, fva) : -1;
      if (fvv)
        for (int kk = 0; kk < 3; kk++) for (int e = 0; e < N; e++)
          if (m_val[kk][e] && (((m_tag[kk][e] ^ fla[VA_W-1:21]) & kmask(kk)) == '0))
            m_val[kk][e] = 0;
      if (fv && fl != 0) begin
        int slot;
        slot = (dup >= 0) ? dup : m_ptr[k];
        if (dup < 0) m_ptr[k] = (m_ptr[k] + 1) % N;
        m_val[k][slot] = 1;
        m_tag[k][slot] = fva[VA_W-1:21] & kmask(k);
        m_base[k][slot] = fb;
      end
    end
  endtask

  task automatic look(input logic [VA_W-1:0] va, input string req);
    cyc(1, va, 0, 0, '0, '0, 0, 0, '0, req);
  endtask

  task automatic fill(input logic [1:0] l, input logic [VA_W-1:0] va,
                      input logic [BASE_W-1:0] b, input string req);
    cyc(1, va, 1, l, va, b, 0, 0, '0, req);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VA_W-1:0] A, B, C, D, E, F, G, H;
    void'($urandom(32'd2024));
    model_reset();
    A = mkva(1, 1, 1, 21'h0abc);
    B = mkva(1, 1, 2, 0); C = mkva(1, 1, 3, 0); D = mkva(1, 1, 4, 0);
    E = mkva(1, 1, 5, 0); F = mkva(7, 7, 7, 0); G = mkva(2, 0, 0, 0); H = mkva(3, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(A, "R1");
    fill(3, A, 40'h111, "R6");
    look(A, "R4");
    look(mkva(1, 5, 6, 21'h1fffff), "R3");
    look(mkva(2, 1, 1, 21'h0abc), "R3");
    fill(2, A, 40'h222, "R4");
    fill(1, A, 40'h333, "R4");
    look(A, "R5");
    look(mkva(1, 1, 9, 0), "R5");
    look(mkva(1, 2, 1, 0), "R5");
    fill(1, A, 40'h444, "R7");
    look(A, "R7");
    fill(1, B, 40'h555, "R8");
    fill(1, C, 40'h666, "R8");
    fill(1, D, 40'h777, "R8");
    look(A, "R7");
    fill(1, E, 40'h888, "R8");
    look(A, "R8");
    look(B, "R8");
    look(E, "R8");
    fill(0, F, 40'h999, "R4");
    look(F, "R4");
    cyc(1, A, 1, 3, G, 40'haaa, 0, 1, A, "R10");
    look(A, "R10");
    look(B, "R10");
    look(G, "R10");
    cyc(1, G, 1, 3, H, 40'hbbb, 1, 0, '0, "R9");
    look(H, "R9");
    look(G, "R9");
    fill(2, B, 40'hccc, "R6");
    cyc(0, B, 0, 0, '0, '0, 0, 0, '0, "R2");
    look(mkva(1, 1, 0, 0), "R2");
    for (int i = 0; i < 3000; i++) begin
      logic [VA_W-1:0] va, fva, xva;
      logic lv, fv, fa, fvv;
      logic [1:0] fl;
      va  = mkva($urandom_range(1, 2), $urandom_range(0, 2), $urandom_range(0, 2), 21'($urandom));
      fva = mkva($urandom_range(1, 2), $urandom_range(0, 2), $urandom_range(0, 2), 21'($urandom));
      xva = mkva($urandom_range(1, 2), $urandom_range(0, 2), $urandom_range(0, 2), 21'($urandom));
      lv  = ($urandom_range(0, 7) != 0);
      fv  = ($urandom_range(0, 2) == 0);
      fl  = 2'($urandom_range(0, 3));
      fa  = ($urandom_range(0, 49) == 0);
      fvv = ($urandom_range(0, 14) == 0);
      cyc(lv, va, fv, fl, fva, 40'($urandom), fa, fvv, xva, "R5");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule